// File: doc/BRIEF.md
# Phase-to-Amplitude Sine/Cosine Converter

This block turns a 13-bit phase word into a 12-bit amplitude sample. The phase covers one full cycle as `phase / 8192`. One select input chooses a sine or a cosine. A second select input chooses between two's-complement and offset-binary coding of the sample. The amplitude swings symmetrically by ±2047 around the mid level, so the most negative code is never produced.

It sits after a phase accumulator in a numerically controlled oscillator and accepts one new phase every clock. Cosine is made by advancing the phase a quarter cycle, which lets both modes share one datapath. The phase is folded into the first quadrant, and the magnitude is computed by a pipelined rotation (shift-and-add) stage per iteration. The sign is restored at the end, and the coding is then applied.

The selects travel down the pipeline beside the data, so a mode change lines up with the sample it belongs to. The fixed latency is `STAGES + 2` clocks (18 by default). An upstream increment register and accumulator add two more clocks, which gives 20 clocks in total from a new increment to a new output frequency.

Top module: `phase_to_sine`

## Requirements
- R1: With `sine_sel_i` high, the signed value of every sample is within 1 LSB of 2047·sin(2π·phase/8192).
- R2: With `sine_sel_i` low, the signed value of every sample is within 1 LSB of 2047·cos(2π·phase/8192).
- R3: With `twos_sel_i` high, the sample is two's complement: 0x7FF is +2047, 0x000 is zero, 0x801 is −2047, and 0x800 is never produced.
- R4: With `twos_sel_i` low, the sample is offset binary: the signed value plus 2048, in the range 0x001..0xFFF, with 0x800 at mid level and 0x000 never produced. For the same phase and function, it equals the two's-complement code with bit 11 inverted.
- R5: The waveform is exactly symmetric. The sine at phase p equals the sine at 4096−p, and the sine at p+4096 (mod 8192) is the exact negative of the sine at p. The cosine at p equals the cosine at 8192−p.
- R6: A sample appears on `amp_o` exactly 18 clocks after its inputs are sampled, and a select change affects only the samples taken with it.
- R7: While `rst_n` is low, `amp_o` is 0x000.
- R8: At the cardinal phases the sine is exact: 0 at phases 0 and 4096, +2047 at phase 2048, and −2047 at phase 6144.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 13 | Phase word, full cycle = 8192 |
| sine_sel_i | input | 1 | 1 = sine, 0 = cosine |
| twos_sel_i | input | 1 | 1 = two's complement, 0 = offset binary |
| amp_o | output | 12 | Amplitude sample |

## Verification
The bench sweeps every phase in several function and coding combinations and compares each sample with a real-valued sine or cosine, so it catches a rotation constant or rounding slip that drifts past one LSB near the peaks. It switches both selects every cycle, which exposes a select that is registered one stage early or late and so gives a sample in the wrong function or code. Folding faults at quadrant edges show up in two ways: as a broken mirror or negation pair, and as a wrong value at the cardinal phases. For example, a mirror that uses 2047−a instead of 2048−a shifts the whole second quadrant. A missing clamp or a plain negation would emit the forbidden code 0x800 or 0x000, and that is checked on every sample.

// File: rtl/phase_to_sine.sv
module phase_to_sine #(
  parameter int PHASE_W = 13,
  parameter int AMP_W   = 12,
  parameter int STAGES  = 16,
  parameter int FRAC_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               sine_sel_i,
  input  logic               twos_sel_i,
  output logic [AMP_W-1:0]   amp_o
);
  localparam int QW      = PHASE_W - 2;
  localparam int AMP     = (1 << (AMP_W - 1)) - 1;
  localparam int DW      = AMP_W + FRAC_W + 2;
  localparam int ZW      = 24;
  localparam int ZMUL    = 51472;
  localparam int ZSH     = QW - 5;
  localparam int ZMAX    = ((1 << QW) * ZMUL) >>> ZSH;
  localparam longint X0  = (longint'(AMP) * 39797 * (longint'(1) << FRAC_W)) >>> 16;
  localparam int LATENCY = STAGES + 2;

  function automatic int atan_q20(input int i);
    case (i)
      0: return 823550;
      1: return 486170;
      2: return 256879;
      3: return 130396;
      4: return 65451;
      5: return 32757;
      6: return 16383;
      7: return 8192;
      default: return (i <= 20) ? (1 << (20 - i)) : 0;
    endcase
  endfunction

  localparam int RES_LIM = 2 * atan_q20(STAGES - 1) + STAGES;

  logic [PHASE_W-1:0] ph_eff;
  logic [1:0]         quad;
  logic [QW:0]        fold;

  assign ph_eff = sine_sel_i ? phase_i : phase_i + PHASE_W'(1 << QW);
  assign quad   = ph_eff[PHASE_W-1 -: 2];
  assign fold   = quad[0] ? (QW+1)'(1 << QW) - {1'b0, ph_eff[QW-1:0]}
                          : {1'b0, ph_eff[QW-1:0]};

  logic signed [DW-1:0] x_q [0:STAGES];
  logic signed [DW-1:0] y_q [0:STAGES];
  logic signed [ZW-1:0] z_q [0:STAGES];
  logic                 neg_q [0:STAGES];
  logic                 tc_q  [0:STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) begin
        x_q[i]   <= '0;
        y_q[i]   <= '0;
        z_q[i]   <= '0;
        neg_q[i] <= 1'b0;
        tc_q[i]  <= 1'b1;
      end
    end else begin
      x_q[0]   <= DW'(X0);
      y_q[0]   <= '0;
      z_q[0]   <= ZW'((int'(fold) * ZMUL) >>> ZSH);
      neg_q[0] <= quad[1];
      tc_q[0]  <= twos_sel_i;
      for (int i = 0; i < STAGES; i++) begin
        if (z_q[i] >= 0) begin
          x_q[i+1] <= x_q[i] - (y_q[i] >>> i);
          y_q[i+1] <= y_q[i] + (x_q[i] >>> i);
          z_q[i+1] <= z_q[i] - ZW'(atan_q20(i));
        end else begin
          x_q[i+1] <= x_q[i] + (y_q[i] >>> i);
          y_q[i+1] <= y_q[i] - (x_q[i] >>> i);
          z_q[i+1] <= z_q[i] + ZW'(atan_q20(i));
        end
        neg_q[i+1] <= neg_q[i];
        tc_q[i+1]  <= tc_q[i];
      end
    end
  end

  logic signed [DW-1:0] y_rnd;
  logic [AMP_W-2:0]     mag;
  logic [AMP_W-1:0]     sval;
  logic [AMP_W-1:0]     code;
  logic                 tc_out_q;

  assign y_rnd = (y_q[STAGES] + DW'(1 <<< (FRAC_W - 1))) >>> FRAC_W;

  always_comb begin
    if (y_rnd < 0)             mag = '0;
    else if (y_rnd > DW'(AMP)) mag = (AMP_W-1)'(AMP);
    else                       mag = y_rnd[AMP_W-2:0];
  end

  assign sval = neg_q[STAGES] ? AMP_W'(0) - {1'b0, mag} : {1'b0, mag};
  assign code = tc_q[STAGES] ? sval : {~sval[AMP_W-1], sval[AMP_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_o    <= '0;
      tc_out_q <= 1'b1;
    end else begin
      amp_o    <= code;
      tc_out_q <= tc_q[STAGES];
    end
  end

  // R3
  twos_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out_q |-> amp_o != {1'b1, {(AMP_W-1){1'b0}}});

  // R4
  offset_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_out_q |-> amp_o != '0);

  // R5
  fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_q[0] >= 0 && z_q[0] <= ZW'(ZMAX));

  // R1
  residual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_q[STAGES] <= ZW'(RES_LIM) && z_q[STAGES] >= -ZW'(RES_LIM));

  // R1
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_rnd >= -1 && y_rnd <= DW'(AMP + 1));

  // R6
  latency_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(neg_q[STAGES-1]) == neg_q[STAGES]);

  initial begin
    // R6
    latency_cfg_chk: assert (LATENCY == STAGES + 2 && QW >= 5);
  end
endmodule

// File: tb/tb_phase_to_sine.sv
module tb_phase_to_sine;
  localparam int LAT = 18;
  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] phase_i = '0;
  logic        sine_sel_i = 1'b1;
  logic        twos_sel_i = 1'b1;
  logic [11:0] amp_o;

  phase_to_sine dut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
    .sine_sel_i(sine_sel_i), .twos_sel_i(twos_sel_i), .amp_o(amp_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    int    ph;
    bit    s;
    bit    tc;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  int    res [0:3][0:8191];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int ph, bit s, bit tc, string tag);
    item_t it;
    @(negedge clk);
    phase_i    = 13'(ph);
    sine_sel_i = s;
    twos_sel_i = tc;
    it.due = cyc + LAT;
    it.ph  = ph;
    it.s   = s;
    it.tc  = tc;
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due < cyc) begin
      check(0, "R6 missed slot", cyc, q[0].due);
      void'(q.pop_front());
    end
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      int    sv;
      real   ideal;
      real   diff;
      it = q.pop_front();
      if (it.tc) sv = (amp_o >= 12'h800) ? int'(amp_o) - 4096 : int'(amp_o);
      else       sv = int'(amp_o) - 2048;
      ideal = 2047.0 * (it.s ? $sin(2.0 * PI * it.ph / 8192.0)
                             : $cos(2.0 * PI * it.ph / 8192.0));
      diff = real'(sv) - ideal;
      if (diff < 0.0) diff = -diff;
      check(diff <= 1.0, it.s ? {"R1 ", it.tag} : {"R2 ", it.tag}, sv, int'(ideal));
      if (it.tc) check(amp_o != 12'h800, "R3 forbidden code", int'(amp_o), 12'h801);
      else       check(amp_o != 12'h000, "R4 forbidden code", int'(amp_o), 12'h001);
      if (it.s && (it.ph % 2048) == 0) begin
        int ex;
        ex = (it.ph == 2048) ? 2047 : (it.ph == 6144) ? -2047 : 0;
        check(sv == ex, "R8 cardinal", sv, ex);
      end
      res[{it.s, it.tc}][it.ph] = sv;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 8192; p++) res[m][p] = 99999;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(amp_o == 12'h000, "R7 reset", int'(amp_o), 0);
    repeat (2) @(negedge clk);
    check(amp_o == 12'h000, "R7 reset", int'(amp_o), 0);
    rst_n = 1'b1;

    for (int p = 0; p < 8192; p++) drive(p, 1'b1, 1'b1, "sine twos sweep");
    for (int p = 0; p < 8192; p++) drive(p, 1'b0, 1'b0, "cos offset sweep");
    for (int p = 0; p < 8192; p++) drive(p, 1'b1, 1'b0, "sine offset sweep");
    for (int p = 0; p < 8192; p++) drive(p, 1'b0, 1'b1, "cos twos sweep");
    // R6 selects toggled every cycle
    for (int k = 0; k < 4096; k++)
      drive((k * 37) % 8192, k[0], k[1], "R6 alternating selects");
    // R6 step after a steady run
    for (int k = 0; k < 30; k++) drive(0, 1'b1, 1'b1, "R6 before step");
    for (int k = 0; k < 30; k++) drive(2048, 1'b1, 1'b1, "R6 after step");
    repeat (LAT + 4) @(negedge clk);
    check(q.size() == 0, "R6 drain", q.size(), 0);

    // R5 symmetry
    for (int p = 1; p < 2048; p++) begin
      check(res[3][p] == res[3][4096 - p], "R5 sine mirror", res[3][4096 - p], res[3][p]);
      check(res[3][p + 4096] == -res[3][p], "R5 sine negation", res[3][p + 4096], -res[3][p]);
      check(res[1][p] == res[1][8192 - p], "R5 cosine mirror", res[1][8192 - p], res[1][p]);
    end
    // R4 offset equals twos with top bit inverted
    for (int p = 0; p < 8192; p++) begin
      check(res[2][p] == res[3][p], "R4 sine code relation", res[2][p], res[3][p]);
      check(res[0][p] == res[1][p], "R4 cosine code relation", res[0][p], res[1][p]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule